// File: doc/BRIEF.md
# Interrupt Vector Ring Drainer

This block empties a ring of 16-byte interrupt vectors that another agent fills. It holds its own byte read pointer and compares it with the write pointer. While the two differ, it fetches each vector through a combinational read port, one 32-bit word per cycle, and turns the vector into a one-clock event pulse. When the ring is empty it publishes the read pointer it reached.

Display and hot-plug vectors are qualified by a latched status vector held outside the block. Such a vector fires its event only while its status bit is set, and the same cycle raises a strobe that clears that bit. Other known sources fire without a status check. Unknown vectors are skipped.

When the write pointer reports an overflow, the block drops the oldest entries. It starts at the slot after the write pointer and asks for the overflow flag to be cleared. After each drain it samples the write pointer again, and it keeps draining if new vectors arrived.

Top module: `ivr_drain`

## Requirements
- R1: After reset `rptr_out` is 0 and every pulse output (`disp_evt`, `stat_clr`, `hdmi_evt`, `cp_evt`, `eop_evt`, `idle_evt`, `ovf_clr`, `rptr_wr`) is low.
- R2: Each entry takes exactly two cycles. The first reads word index `rptr/4` and takes the source code from bits [7:0]. The second reads index `rptr/4+1` and takes the data from bits [27:0]. Higher bits of both words are ignored. Draining N entries from idle publishes `rptr_wr` 2N+2 cycles after the write pointer changes.
- R3: Source 1 with data 0 / 1 maps to `disp_evt` bits 0 / 1, and source 5 with data 0 / 1 maps to bits 2 / 3. Each event is one cycle wide, at most one event pulse is high in any cycle, and `stat_clr` equals `disp_evt`.
- R4: Source 19 with data 0, 1, 4, 5, 10, 12 maps to `disp_evt` bits 4, 5, 6, 7, 8, 9 respectively.
- R5: A `disp_evt`/`stat_clr` bit fires only if the matching `stat_in` bit is set in the cycle the entry's data word is read. Otherwise the entry has no effect.
- R6: Source 21 pulses `hdmi_evt`, sources 176, 177 and 178 pulse `cp_evt`, 181 pulses `eop_evt` and 233 pulses `idle_evt`, whatever the data. Any other source, or a source 1/5/19 entry with unlisted data, produces nothing.
- R7: The read pointer advances by 16 after each entry and wraps modulo 2^PTR_W.
- R8: If `wptr_ovf` is high when the write pointer is sampled, draining starts at `wptr_in + 16` (wrapped), and `ovf_clr` pulses for one cycle.
- R9: After reaching the sampled write pointer, the block samples it again. If it moved, draining continues to the new value. Otherwise `rptr_out` takes the final pointer and `rptr_wr` pulses once.
- R10: With `enable` low, or with the read pointer equal to the write pointer, nothing is read, no event fires and `rptr_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows a drain to start |
| wptr_in | input | PTR_W | Producer byte write pointer (16-aligned) |
| wptr_ovf | input | 1 | Producer overflow flag |
| mem_addr | output | PTR_W-2 | Ring word index |
| mem_rdata | input | 32 | Ring word at `mem_addr` (same cycle) |
| stat_in | input | 10 | Latched display/hot-plug status |
| disp_evt | output | 10 | Qualified display/hot-plug event pulses |
| stat_clr | output | 10 | Status bit clear strobes |
| hdmi_evt | output | 1 | Audio/video link event pulse |
| cp_evt | output | 1 | Command processor event pulse |
| eop_evt | output | 1 | End-of-pipe event pulse |
| idle_evt | output | 1 | Graphics idle event pulse |
| ovf_clr | output | 1 | Overflow clear request pulse |
| rptr_out | output | PTR_W | Published read pointer |
| rptr_wr | output | 1 | Publish strobe for `rptr_out` |

## Verification
The bench places two entries for the same display source behind one status bit. A design that does not clear that bit, or that ignores the status vector, would report the event twice. It drains a stretch of the ring that crosses the end of the ring, which catches a pointer that does not wrap, and it includes a hot-plug entry with a high data bit set, which catches a data field decoded too wide. It moves the write pointer in the middle of a drain, where a design without the second sample would publish the stale pointer. It raises an overflow with markers arranged so that starting at the old read pointer, rather than at write pointer plus 16, reverses the order of the events.

// File: rtl/ivr_drain.sv
module ivr_drain #(
  parameter int PTR_W   = 8,
  parameter int WORD_W  = 32,
  parameter int SRC_W   = 8,
  parameter int SDATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PTR_W-1:0]  wptr_in,
  input  logic              wptr_ovf,
  output logic [PTR_W-3:0]  mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [9:0]        stat_in,
  output logic [9:0]        disp_evt,
  output logic [9:0]        stat_clr,
  output logic              hdmi_evt,
  output logic              cp_evt,
  output logic              eop_evt,
  output logic              idle_evt,
  output logic              ovf_clr,
  output logic [PTR_W-1:0]  rptr_out,
  output logic              rptr_wr
);
  localparam int IDX_W = PTR_W - 2;
  localparam logic [PTR_W-1:0] STEP = PTR_W'(16);
  localparam logic [SRC_W-1:0] SRC_D1 = SRC_W'(1),   SRC_D2 = SRC_W'(5),
                               SRC_HP = SRC_W'(19),  SRC_AV = SRC_W'(21),
                               SRC_C0 = SRC_W'(176), SRC_C1 = SRC_W'(177),
                               SRC_C2 = SRC_W'(178), SRC_EOP = SRC_W'(181),
                               SRC_IDLE = SRC_W'(233);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_CHK} st_t;
  st_t st;

  logic [PTR_W-1:0]   rp, wq;
  logic [SRC_W-1:0]   src_q;
  logic [SDATA_W-1:0] sdat;
  logic [9:0]         dhit;
  logic               hdmi_h, cp_h, eop_h, idle_h;
  logic [PTR_W-1:0]   start_rp;
  logic               unused_hi;

  assign sdat      = mem_rdata[SDATA_W-1:0];
  assign unused_hi = &{1'b0, mem_rdata[WORD_W-1:SDATA_W]};
  assign mem_addr  = rp[PTR_W-1:2] + IDX_W'(st == S_HI);
  assign start_rp  = wptr_ovf ? wptr_in + STEP : rp;
  assign stat_clr  = disp_evt;

  always_comb begin
    dhit = '0; hdmi_h = 1'b0; cp_h = 1'b0; eop_h = 1'b0; idle_h = 1'b0;
    case (src_q)
      SRC_D1:  if (sdat == SDATA_W'(0)) dhit[0] = 1'b1;
               else if (sdat == SDATA_W'(1)) dhit[1] = 1'b1;
      SRC_D2:  if (sdat == SDATA_W'(0)) dhit[2] = 1'b1;
               else if (sdat == SDATA_W'(1)) dhit[3] = 1'b1;
      SRC_HP:  case (sdat)
                 SDATA_W'(0):  dhit[4] = 1'b1;
                 SDATA_W'(1):  dhit[5] = 1'b1;
                 SDATA_W'(4):  dhit[6] = 1'b1;
                 SDATA_W'(5):  dhit[7] = 1'b1;
                 SDATA_W'(10): dhit[8] = 1'b1;
                 SDATA_W'(12): dhit[9] = 1'b1;
                 default: ;
               endcase
      SRC_AV:  hdmi_h = 1'b1;
      SRC_C0, SRC_C1, SRC_C2: cp_h = 1'b1;
      SRC_EOP: eop_h = 1'b1;
      SRC_IDLE: idle_h = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rp <= '0; wq <= '0; src_q <= '0;
      disp_evt <= '0; hdmi_evt <= 1'b0; cp_evt <= 1'b0; eop_evt <= 1'b0;
      idle_evt <= 1'b0; ovf_clr <= 1'b0; rptr_out <= '0; rptr_wr <= 1'b0;
    end else begin
      disp_evt <= '0; hdmi_evt <= 1'b0; cp_evt <= 1'b0; eop_evt <= 1'b0;
      idle_evt <= 1'b0; ovf_clr <= 1'b0; rptr_wr <= 1'b0;
      case (st)
        S_IDLE: if (enable) begin
          wq <= wptr_in;
          rp <= start_rp;
          ovf_clr <= wptr_ovf;
          if (start_rp != wptr_in) st <= S_LO;
        end
        S_LO: begin
          src_q <= mem_rdata[SRC_W-1:0];
          st <= S_HI;
        end
        S_HI: begin
          disp_evt <= dhit & stat_in;
          hdmi_evt <= hdmi_h;
          cp_evt   <= cp_h;
          eop_evt  <= eop_h;
          idle_evt <= idle_h;
          rp <= rp + STEP;
          st <= (rp + STEP == wq) ? S_CHK : S_LO;
        end
        default: begin
          if (wptr_ovf || wptr_in != wq) begin
            wq <= wptr_in;
            rp <= start_rp;
            ovf_clr <= wptr_ovf;
            st <= S_LO;
          end else begin
            rptr_out <= rp;
            rptr_wr <= 1'b1;
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  p_addr_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI) |-> mem_addr == IDX_W'($past(mem_addr) + 1'b1));
  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disp_evt, hdmi_evt, cp_evt, eop_evt, idle_evt}));
  p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_evt) |-> ((disp_evt & ~$past(stat_in)) == '0));
  p_ovf_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |-> $past(wptr_ovf));
  p_publish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_wr |-> rptr_out == $past(wptr_in));
  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> st == S_IDLE);
endmodule

// File: tb/ivr_drain_test.sv
`timescale 1ns/1ps
module ivr_drain_test;
  logic clk = 0, rst_n = 0, enable = 0, wptr_ovf = 0;
  logic [7:0] wptr_in = '0;
  logic [5:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [9:0] stat_in = '0, disp_evt, stat_clr;
  logic hdmi_evt, cp_evt, eop_evt, idle_evt, ovf_clr, rptr_wr;
  logic [7:0] rptr_out;
  logic [31:0] mem [0:63];
  int n_chk = 0, n_fail = 0, n_ovf = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  ivr_drain uut (.clk(clk), .rst_n(rst_n), .enable(enable), .wptr_in(wptr_in),
    .wptr_ovf(wptr_ovf), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .stat_in(stat_in),
    .disp_evt(disp_evt), .stat_clr(stat_clr), .hdmi_evt(hdmi_evt), .cp_evt(cp_evt),
    .eop_evt(eop_evt), .idle_evt(idle_evt), .ovf_clr(ovf_clr), .rptr_out(rptr_out),
    .rptr_wr(rptr_wr));

  always @(posedge clk) begin
    stat_in <= stat_in & ~stat_clr;
    if (ovf_clr) begin wptr_ovf <= 1'b0; n_ovf++; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int code, input string tag);
    exp_q.push_back(code); tag_q.push_back(tag);
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [13:0] ev;
    ev = {idle_evt, eop_evt, cp_evt, hdmi_evt, disp_evt};
    if (disp_evt != 0) chk(stat_clr == disp_evt, "R3 clear strobe", stat_clr, disp_evt);
    for (int i = 0; i < 14; i++) if (ev[i]) begin
      if (exp_q.size() == 0) chk(0, "unexpected event", i, -1);
      else begin
        int e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(e == i, t, i, e);
      end
    end
  end

  task automatic put(input int ba, input int src, input int data);
    mem[ba/4]   = 32'h5AA5A500 | (src & 8'hFF);
    mem[ba/4+1] = data;
  endtask

  task automatic wait_pub(input int exp_r, input int exp_cyc, input string tag);
    int cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rptr_wr && cyc < 300);
    chk(rptr_wr == 1'b1, {tag, " publish"}, rptr_wr, 1);
    chk(rptr_out == exp_r[7:0], {tag, " pointer"}, rptr_out, exp_r);
    if (exp_cyc > 0) chk(cyc == exp_cyc, "R2 drain latency", cyc, exp_cyc);
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " missing events"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rptr_out == 0 && !rptr_wr && !ovf_clr && disp_evt == 0, "R1 reset", rptr_out, 0);
    enable = 1;
    repeat (2) @(negedge clk);

    // R3 display decode, R2 latency for 4 entries
    put(8'h00, 1, 0); put(8'h10, 1, 1); put(8'h20, 5, 0); put(8'h30, 5, 1);
    stat_in = 10'h00F;
    expect_ev(0, "R3 d1 vblank"); expect_ev(1, "R3 d1 vline");
    expect_ev(2, "R3 d2 vblank"); expect_ev(3, "R3 d2 vline");
    wptr_in = 8'h40;
    wait_pub(8'h40, 10, "R9 display");
    chk(stat_in == 0, "R3 status cleared", stat_in, 0);

    // R4 hot-plug map; R2 data field is low 28 bits
    put(8'h40, 19, 0); put(8'h50, 19, 12); put(8'h60, 19, 4);
    put(8'h70, 19, 32'h1000_0001); put(8'h80, 19, 10); put(8'h90, 19, 5);
    stat_in = 10'h3F0;
    expect_ev(4, "R4 hp ch1"); expect_ev(9, "R4 hp ch6"); expect_ev(6, "R4 hp ch3");
    expect_ev(5, "R2 hp ch2 high data bits"); expect_ev(8, "R4 hp ch5"); expect_ev(7, "R4 hp ch4");
    wptr_in = 8'hA0;
    wait_pub(8'hA0, 14, "R4 hotplug");

    // R5 gating: only one of three qualifies, duplicate suppressed
    put(8'hA0, 1, 0); put(8'hB0, 5, 0); put(8'hC0, 5, 0);
    stat_in = 10'h004;
    expect_ev(2, "R5 gated once");
    wptr_in = 8'hD0;
    wait_pub(8'hD0, 0, "R5 gating");
    chk(stat_in == 0, "R5 status after", stat_in, 0);

    // R6 ungated sources and ignored codes, R7 wrap
    put(8'hD0, 21, 4); put(8'hE0, 176, 3); put(8'hF0, 177, 0); put(8'h00, 178, 9);
    put(8'h10, 181, 0); put(8'h20, 233, 0); put(8'h30, 7, 0); put(8'h40, 1, 2);
    put(8'h50, 19, 2);
    stat_in = 10'h3FF;
    expect_ev(10, "R6 hdmi"); expect_ev(11, "R6 cp ring"); expect_ev(11, "R6 cp ib1");
    expect_ev(11, "R7 cp ib2 after wrap"); expect_ev(12, "R6 eop"); expect_ev(13, "R6 idle");
    wptr_in = 8'h60;
    wait_pub(8'h60, 0, "R7 wrap");
    chk(stat_in == 10'h3FF, "R6 ignored codes keep status", stat_in, 10'h3FF);
    stat_in = 0;

    // R10 disabled
    put(8'h60, 233, 0);
    enable = 0;
    wptr_in = 8'h70;
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (rptr_wr) seen = 1; end
      chk(!seen && rptr_out == 8'h60, "R10 disabled no publish", rptr_out, 8'h60);
    end
    expect_ev(13, "R10 resumes after enable");
    enable = 1;
    wait_pub(8'h70, 0, "R10 enable");

    // R9 write pointer moves during drain
    for (int a = 8'h70; a < 8'hC0; a += 16) put(a, 181, 0);
    for (int i = 0; i < 5; i++) expect_ev(12, "R9 restart eop");
    wptr_in = 8'h90;
    repeat (3) @(negedge clk);
    wptr_in = 8'hC0;
    wait_pub(8'hC0, 0, "R9 restart");

    // R8 overflow: start at wptr+16, event order shows the start point
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put(8'h50, 181, 0); put(8'hC0, 21, 0);
    expect_ev(12, "R8 first after overflow"); expect_ev(10, "R8 second after overflow");
    n_ovf = 0;
    wptr_in = 8'h40; wptr_ovf = 1;
    wait_pub(8'h40, 0, "R8 overflow");
    chk(n_ovf == 1, "R8 clear request count", n_ovf, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule